// File: doc/BRIEF.md
# CHS Sector Address Sequencer

This block converts a cylinder/head/sector disk address into a linear byte offset and then walks a multi-sector transfer one 512-byte sector at a time. A host loads the cylinder as two byte registers, a head number, a starting sector number (counted from 1), a sector count and a drive-select bit, and pulses a start strobe. The per-drive geometry (heads per cylinder and sectors per track) comes in as two small tables indexed by the drive-select bit.

After a fixed multiply pipeline the block presents the first sector request: a valid flag, the 40-bit byte offset and a flag marking the final sector. The data mover acknowledges each sector with a one-cycle done strobe; the block then moves the offset forward by one sector and counts the remaining sectors down. When the final sector is acknowledged the block returns to idle and emits a one-cycle completion pulse.

Top module: `chs_seq_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy_o`, `req_valid_o`, `req_last_o` and `done_o` are all low.
- R2: The cylinder used for the address equals `cyl_hi_i` × 256 + `cyl_lo_i`.
- R3: The first request offset equals 512 × ((sector − 1) + head × SPT + HEADS × SPT × cylinder), where HEADS and SPT are the table entries for the selected drive: drive d uses bits [5d+4:5d] of `heads_tbl_i` and bits [8d+7:8d] of `spt_tbl_i`.
- R4: A start sampled at clock edge k while idle raises `busy_o` from edge k; `req_valid_o` stays low through edge k+2 and is high after edge k+3.
- R5: While a request is valid and `sec_done_i` is low, offset and last flag hold; a sampled `sec_done_i` on a non-final sector advances the offset by exactly 512 and keeps the request valid.
- R6: A sector count of 0 produces 256 sector requests; any other count N produces exactly N.
- R7: `req_last_o` is high only while the final sector of the transfer is being requested.
- R8: The handshake on the final sector is followed by `done_o` high for exactly one cycle, during which `busy_o` is already low.
- R9: A start strobe while busy has no effect on the transfer in progress.
- R10: A `sec_done_i` strobe while no request is valid is ignored and does not consume a sector.
- R11: Address, count, drive and geometry inputs are sampled only at the accepted start; later changes do not alter the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| cyl_lo_i | input | 8 | Cylinder low byte |
| cyl_hi_i | input | 8 | Cylinder high byte |
| head_i | input | 4 | Head number |
| sector_i | input | 8 | Starting sector, 1-based |
| count_i | input | 8 | Sector count, 0 means 256 |
| drive_i | input | 1 | Drive select |
| heads_tbl_i | input | 10 | Heads per cylinder, 5 bits per drive |
| spt_tbl_i | input | 16 | Sectors per track, 8 bits per drive |
| sec_done_i | input | 1 | Current sector finished |
| busy_o | output | 1 | Transfer in progress |
| req_valid_o | output | 1 | Sector request valid |
| req_offset_o | output | 40 | Byte offset of the requested sector |
| req_last_o | output | 1 | Requested sector is the final one |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps every head and every sector number of two small geometries over cylinders that cross the byte boundary (0, 255, 256, 65535), so a design that swapped the cylinder bytes, dropped the minus-one on the sector, or picked the wrong drive's geometry produces offsets that miscompare. A count of zero is run to its full 256 sectors, catching a design that treats it as zero or one transfer, and the maximum geometry exercises the top bits of the product where a narrow intermediate would truncate. Stalled handshakes, strobes while busy or between requests, and geometry changes after start are applied to show that nothing but an accepted done advances the sequence.

// File: rtl/chs_pkg.sv
// Shared definitions for the CHS sector address sequencer.
// Assumes: one sequencer state register per instance; sector size is a power of two.
package chs_pkg;

    // Control states of the sequencer.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_MUL1 = 3'd1,
        ST_MUL2 = 3'd2,
        ST_SUM  = 3'd3,
        ST_REQ  = 3'd4
    } seq_state_t;

    // log2 of the sector size in bytes.
    localparam int SECT_LOG2 = 9;

endpackage

// File: rtl/chs_geom_sel.sv
// Geometry table lookup: splits the flat per-drive tables into entries and
// returns heads-per-cylinder and sectors-per-track for the selected drive.
// Assumes: drive_i is below NDRIVE; purely combinational.
module chs_geom_sel #(
    parameter int NDRIVE  = 2,
    parameter int GHEAD_W = 5,
    parameter int SPT_W   = 8,
    parameter int DSEL_W  = 1
) (
    input  logic [NDRIVE*GHEAD_W-1:0] heads_tbl_i,
    input  logic [NDRIVE*SPT_W-1:0]   spt_tbl_i,
    input  logic [DSEL_W-1:0]         drive_i,
    output logic [GHEAD_W-1:0]        heads_o,
    output logic [SPT_W-1:0]          spt_o
);

    logic [GHEAD_W-1:0] heads_arr [NDRIVE];
    logic [SPT_W-1:0]   spt_arr   [NDRIVE];

    // Unpack one table entry per drive.
    for (genvar d = 0; d < NDRIVE; d++) begin : g_unpack
        assign heads_arr[d] = heads_tbl_i[d*GHEAD_W +: GHEAD_W];
        assign spt_arr[d]   = spt_tbl_i[d*SPT_W +: SPT_W];
    end

    // Select the entry of the requested drive.
    always_comb begin
        heads_o = heads_arr[drive_i];
        spt_o   = spt_arr[drive_i];
    end

endmodule

// File: rtl/chs_offset_pipe.sv
// Offset arithmetic: latches the CHS operands at start, then forms the linear
// sector number over two registered multiply stages and a final adder.
// Assumes: operands stay latched for at least two cycles after load_i before
// base_off_o is consumed; sector_i is 1-based.
module chs_offset_pipe #(
    parameter int REG_W     = 8,
    parameter int HEAD_W    = 4,
    parameter int GHEAD_W   = 5,
    parameter int SPT_W     = 8,
    parameter int OFF_W     = 40,
    parameter int SECT_LOG2 = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [REG_W-1:0]    cyl_lo_i,
    input  logic [REG_W-1:0]    cyl_hi_i,
    input  logic [HEAD_W-1:0]   head_i,
    input  logic [REG_W-1:0]    sector_i,
    input  logic [GHEAD_W-1:0]  heads_i,
    input  logic [SPT_W-1:0]    spt_i,
    output logic [OFF_W-1:0]    base_off_o
);

    localparam int CYL_W   = 2 * REG_W;
    localparam int HSPT_W  = GHEAD_W + SPT_W;
    localparam int HSEC_W  = HEAD_W + SPT_W;
    localparam int NEAR_W  = ((HSEC_W > REG_W) ? HSEC_W : REG_W) + 1;
    localparam int CTERM_W = CYL_W + HSPT_W;
    localparam int LBA_W   = ((CTERM_W > NEAR_W) ? CTERM_W : NEAR_W) + 1;

    logic [CYL_W-1:0]   cyl_q;
    logic [HEAD_W-1:0]  head_q;
    logic [REG_W-1:0]   sector_q;
    logic [GHEAD_W-1:0] heads_q;
    logic [SPT_W-1:0]   spt_q;

    logic [HSPT_W-1:0]  hs_s1;
    logic [HSEC_W-1:0]  hsec_s1;
    logic [REG_W-1:0]   s0_s1;
    logic [CYL_W-1:0]   cyl_s1;

    logic [CTERM_W-1:0] cterm_s2;
    logic [NEAR_W-1:0]  near_s2;
    logic [LBA_W-1:0]   lba;

    // Operand latch: capture address and geometry at an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyl_q    <= '0;
            head_q   <= '0;
            sector_q <= '0;
            heads_q  <= '0;
            spt_q    <= '0;
        end else if (load_i) begin
            cyl_q    <= {cyl_hi_i, cyl_lo_i};
            head_q   <= head_i;
            sector_q <= sector_i;
            heads_q  <= heads_i;
            spt_q    <= spt_i;
        end
    end

    // Stage 1: per-cylinder sector product, head term and zero-based sector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_s1   <= '0;
            hsec_s1 <= '0;
            s0_s1   <= '0;
            cyl_s1  <= '0;
        end else begin
            hs_s1   <= HSPT_W'(heads_q) * HSPT_W'(spt_q);
            hsec_s1 <= HSEC_W'(head_q) * HSEC_W'(spt_q);
            s0_s1   <= sector_q - REG_W'(1);
            cyl_s1  <= cyl_q;
        end
    end

    // Stage 2: cylinder term and the in-cylinder sector index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cterm_s2 <= '0;
            near_s2  <= '0;
        end else begin
            cterm_s2 <= CTERM_W'(hs_s1) * CTERM_W'(cyl_s1);
            near_s2  <= NEAR_W'(hsec_s1) + NEAR_W'(s0_s1);
        end
    end

    // Final adder and scaling to bytes; registered by the step controller.
    always_comb begin
        lba        = LBA_W'(cterm_s2) + LBA_W'(near_s2);
        base_off_o = OFF_W'(lba) << SECT_LOG2;
    end

endmodule

// File: rtl/chs_step_ctrl.sv
// Step controller: sequences the multiply pipeline, then issues one sector
// request per handshake with a running offset and remaining count.
// Assumes: base_off_i is valid in ST_SUM; sec_done_i is a single-cycle strobe.
module chs_step_ctrl
    import chs_pkg::*;
#(
    parameter int REG_W     = 8,
    parameter int OFF_W     = 40,
    parameter int SECT_LOG2 = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [REG_W-1:0] count_i,
    input  logic             sec_done_i,
    input  logic [OFF_W-1:0] base_off_i,
    output logic             load_o,
    output logic             busy_o,
    output logic             req_valid_o,
    output logic [OFF_W-1:0] req_offset_o,
    output logic             req_last_o,
    output logic             done_o
);

    localparam int CNT_W = REG_W + 1;
    localparam logic [OFF_W-1:0] STEP = OFF_W'(1) << SECT_LOG2;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(1) << REG_W;

    seq_state_t       state_q;
    logic [CNT_W-1:0] rem_q;
    logic [OFF_W-1:0] off_q;
    logic             done_q;
    logic             accept;

    // Start acceptance and handshake qualification.
    always_comb begin
        load_o = (state_q == ST_IDLE) && start_i;
        accept = (state_q == ST_REQ) && sec_done_i;
    end

    // State, remaining count, running offset and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
            off_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (load_o) begin
                        state_q <= ST_MUL1;
                        rem_q   <= (count_i == '0) ? FULL : CNT_W'(count_i);
                    end
                end
                ST_MUL1: state_q <= ST_MUL2;
                ST_MUL2: state_q <= ST_SUM;
                ST_SUM: begin
                    off_q   <= base_off_i;
                    state_q <= ST_REQ;
                end
                ST_REQ: begin
                    if (accept) begin
                        if (rem_q == CNT_W'(1)) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            off_q <= off_q + STEP;
                        end
                        rem_q <= rem_q - CNT_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output view of the sequencer state.
    always_comb begin
        busy_o       = (state_q != ST_IDLE);
        req_valid_o  = (state_q == ST_REQ);
        req_last_o   = (state_q == ST_REQ) && (rem_q == CNT_W'(1));
        req_offset_o = off_q;
        done_o       = done_q;
    end

endmodule

// File: rtl/chs_seq_top.sv
// CHS sector address sequencer top: geometry lookup, offset pipeline and
// step controller. Assumes synchronous active-low reset and 1-based sectors.
module chs_seq_top #(
    parameter int NDRIVE  = 2,
    parameter int REG_W   = 8,
    parameter int HEAD_W  = 4,
    parameter int GHEAD_W = 5,
    parameter int SPT_W   = 8,
    parameter int OFF_W   = 40,
    localparam int DSEL_W = (NDRIVE > 1) ? $clog2(NDRIVE) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [REG_W-1:0]          cyl_lo_i,
    input  logic [REG_W-1:0]          cyl_hi_i,
    input  logic [HEAD_W-1:0]         head_i,
    input  logic [REG_W-1:0]          sector_i,
    input  logic [REG_W-1:0]          count_i,
    input  logic [DSEL_W-1:0]         drive_i,
    input  logic [NDRIVE*GHEAD_W-1:0] heads_tbl_i,
    input  logic [NDRIVE*SPT_W-1:0]   spt_tbl_i,
    input  logic                      sec_done_i,
    output logic                      busy_o,
    output logic                      req_valid_o,
    output logic [OFF_W-1:0]          req_offset_o,
    output logic                      req_last_o,
    output logic                      done_o
);

    logic [GHEAD_W-1:0] sel_heads;
    logic [SPT_W-1:0]   sel_spt;
    logic [OFF_W-1:0]   base_off;
    logic               load;

    chs_geom_sel #(
        .NDRIVE (NDRIVE),
        .GHEAD_W(GHEAD_W),
        .SPT_W  (SPT_W),
        .DSEL_W (DSEL_W)
    ) u_geom (
        .heads_tbl_i(heads_tbl_i),
        .spt_tbl_i  (spt_tbl_i),
        .drive_i    (drive_i),
        .heads_o    (sel_heads),
        .spt_o      (sel_spt)
    );

    chs_offset_pipe #(
        .REG_W    (REG_W),
        .HEAD_W   (HEAD_W),
        .GHEAD_W  (GHEAD_W),
        .SPT_W    (SPT_W),
        .OFF_W    (OFF_W),
        .SECT_LOG2(chs_pkg::SECT_LOG2)
    ) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .cyl_lo_i  (cyl_lo_i),
        .cyl_hi_i  (cyl_hi_i),
        .head_i    (head_i),
        .sector_i  (sector_i),
        .heads_i   (sel_heads),
        .spt_i     (sel_spt),
        .base_off_o(base_off)
    );

    chs_step_ctrl #(
        .REG_W    (REG_W),
        .OFF_W    (OFF_W),
        .SECT_LOG2(chs_pkg::SECT_LOG2)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .count_i     (count_i),
        .sec_done_i  (sec_done_i),
        .base_off_i  (base_off),
        .load_o      (load),
        .busy_o      (busy_o),
        .req_valid_o (req_valid_o),
        .req_offset_o(req_offset_o),
        .req_last_o  (req_last_o),
        .done_o      (done_o)
    );

endmodule

// File: rtl/chs_seq_chk.sv
// Protocol checker for chs_seq_top, observing its ports only.
// Assumes: synchronous active-low reset on rst_n.
module chs_seq_chk #(
    parameter int OFF_W     = 40,
    parameter int SECT_LOG2 = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             sec_done_i,
    input logic             busy_o,
    input logic             req_valid_o,
    input logic [OFF_W-1:0] req_offset_o,
    input logic             req_last_o,
    input logic             done_o
);

    localparam logic [OFF_W-1:0] STEP = OFF_W'(1) << SECT_LOG2;

    AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> busy_o); // R4

    AST_START_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && !req_valid_o)); // R4

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !sec_done_i) |=>
            (req_valid_o && $stable(req_offset_o) && $stable(req_last_o))); // R5

    AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && sec_done_i && !req_last_o) |=>
            (req_valid_o && req_offset_o == $past(req_offset_o) + STEP)); // R5

    AST_LAST_ONLY_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_last_o |-> req_valid_o); // R7

    AST_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && sec_done_i && req_last_o) |=> (done_o && !busy_o)); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8

endmodule

bind chs_seq_top chs_seq_chk #(
    .OFF_W    (OFF_W),
    .SECT_LOG2(chs_pkg::SECT_LOG2)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .sec_done_i  (sec_done_i),
    .busy_o      (busy_o),
    .req_valid_o (req_valid_o),
    .req_offset_o(req_offset_o),
    .req_last_o  (req_last_o),
    .done_o      (done_o)
);

// File: tb/test_chs_seq_top.sv
module test_chs_seq_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  cyl_lo_i = '0;
    logic [7:0]  cyl_hi_i = '0;
    logic [3:0]  head_i = '0;
    logic [7:0]  sector_i = '0;
    logic [7:0]  count_i = '0;
    logic [0:0]  drive_i = '0;
    logic [9:0]  heads_tbl_i = '0;
    logic [15:0] spt_tbl_i = '0;
    logic        sec_done_i = 1'b0;
    logic        busy_o;
    logic        req_valid_o;
    logic [39:0] req_offset_o;
    logic        req_last_o;
    logic        done_o;

    int n_vec = 0;
    int n_bad = 0;
    bit reported = 1'b0;

    int g_heads [2];
    int g_spt   [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    chs_seq_top i_chs_seq_top (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .cyl_lo_i(cyl_lo_i), .cyl_hi_i(cyl_hi_i), .head_i(head_i),
        .sector_i(sector_i), .count_i(count_i), .drive_i(drive_i),
        .heads_tbl_i(heads_tbl_i), .spt_tbl_i(spt_tbl_i),
        .sec_done_i(sec_done_i), .busy_o(busy_o), .req_valid_o(req_valid_o),
        .req_offset_o(req_offset_o), .req_last_o(req_last_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", rq, $time, act, exp);
        end
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        end
    endtask

    task automatic set_geom(input int h0, input int s0, input int h1, input int s1);
        g_heads[0] = h0; g_spt[0] = s0; g_heads[1] = h1; g_spt[1] = s1;
        heads_tbl_i = {5'(h1), 5'(h0)};
        spt_tbl_i   = {8'(s1), 8'(s0)};
    endtask

    // Byte offset per R2/R3.
    function automatic longint exp_off(input int drv, input int cyl, input int hd, input int sec);
        longint lba;
        lba = longint'(sec - 1) + longint'(hd) * g_spt[drv]
            + longint'(g_heads[drv]) * g_spt[drv] * cyl;
        return lba * 512;
    endfunction

    // One transfer; stall inserts idle handshake cycles, poke applies
    // ignored stimulus (done between requests, start while busy, geometry change).
    task automatic xfer(input int drv, input int cyl, input int hd, input int sec,
                        input int cnt, input bit stall, input bit poke);
        longint base;
        int     n;
        int     sh0, ss0, sh1, ss1;
        n    = (cnt == 0) ? 256 : cnt;
        base = exp_off(drv, cyl, hd, sec);
        sh0 = g_heads[0]; ss0 = g_spt[0]; sh1 = g_heads[1]; ss1 = g_spt[1];
        @(negedge clk);
        cyl_lo_i = 8'(cyl); cyl_hi_i = 8'(cyl >> 8); head_i = 4'(hd);
        sector_i = 8'(sec); count_i = 8'(cnt); drive_i = 1'(drv);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o && !req_valid_o, "R4 busy after start", {busy_o, req_valid_o}, 2);
        if (poke) begin
            sec_done_i = 1'b1;                  // R10: ignored during computation
            heads_tbl_i = ~heads_tbl_i;         // R11: later geometry change
            spt_tbl_i   = ~spt_tbl_i;
            cyl_lo_i = ~cyl_lo_i; head_i = ~head_i; count_i = 8'd1;
        end
        @(negedge clk);
        sec_done_i = 1'b0;
        chk(!req_valid_o, "R4 no early request", req_valid_o, 0);
        @(negedge clk);
        chk(!req_valid_o, "R4 no early request", req_valid_o, 0);
        @(negedge clk);
        chk(req_valid_o, "R4 request after pipeline", req_valid_o, 1);
        for (int i = 0; i < n; i++) begin
            chk(req_offset_o == 40'(base + 512 * i), "R3 R5 R6 offset",
                longint'(req_offset_o), base + 512 * i);
            chk(req_last_o == (i == n - 1), "R7 last flag", req_last_o, (i == n - 1));
            chk(req_valid_o && busy_o && !done_o, "R6 request active",
                {req_valid_o, busy_o, done_o}, 6);
            if (stall && (i % 2 == 0)) begin
                @(negedge clk);
                chk(req_offset_o == 40'(base + 512 * i) && req_valid_o,
                    "R5 hold while stalled", longint'(req_offset_o), base + 512 * i);
            end
            if (poke && i == 0) begin
                start_i = 1'b1; sector_i = 8'd9;
                @(negedge clk);
                start_i = 1'b0;
                chk(req_offset_o == 40'(base) && req_valid_o,
                    "R9 start while busy ignored", longint'(req_offset_o), base);
            end
            sec_done_i = 1'b1;
            @(negedge clk);
            sec_done_i = 1'b0;
        end
        chk(done_o && !busy_o && !req_valid_o, "R8 completion pulse",
            {done_o, busy_o, req_valid_o}, 4);
        if (poke) sec_done_i = 1'b1;            // R10: ignored while idle
        @(negedge clk);
        sec_done_i = 1'b0;
        chk(!done_o && !busy_o, "R8 pulse one cycle / R10 idle done", {done_o, busy_o}, 0);
        if (poke) set_geom(sh0, ss0, sh1, ss1);
    endtask

    initial begin
        int cyls [4];
        cyls[0] = 0; cyls[1] = 255; cyls[2] = 256; cyls[3] = 65535;
        set_geom(3, 5, 5, 7);
        start_i = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy_o && !req_valid_o && !req_last_o && !done_o, "R1 reset state",
            {busy_o, req_valid_o, req_last_o, done_o}, 0);
        start_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !req_valid_o && !req_last_o && !done_o, "R1 after reset",
            {busy_o, req_valid_o, req_last_o, done_o}, 0);

        // Sweep: R2 R3 over both drives, all heads, all sectors, boundary cylinders.
        for (int d = 0; d < 2; d++)
            for (int h = 0; h < g_heads[d]; h++)
                for (int s = 1; s <= g_spt[d]; s++)
                    for (int c = 0; c < 4; c++)
                        xfer(d, cyls[c], h, s, (c % 2 == 0) ? 1 : 3, (s % 2 == 1), 1'b0);

        // Count zero means 256 sectors (R6).
        xfer(1, 300, 2, 4, 0, 1'b0, 1'b0);
        // Ignored stimulus (R9 R10 R11).
        xfer(0, 513, 1, 2, 4, 1'b1, 1'b1);
        xfer(1, 258, 4, 7, 2, 1'b0, 1'b1);
        // Maximum geometry and address for width coverage (R3).
        set_geom(16, 255, 1, 1);
        xfer(0, 65535, 15, 255, 3, 1'b0, 1'b0);
        xfer(1, 65535, 0, 1, 2, 1'b1, 1'b0);
        xfer(0, 1, 0, 1, 255, 1'b0, 1'b0);

        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual=0 expected=1");
        summary();
        $finish;
    end

endmodule